// File: doc/BRIEF.md
# Dynamic Bus Sizing Adapter

This block connects a 32-bit internal load/store port to an external data bus whose width can be 32, 16 or 8 bits. It accepts one word, halfword or byte request at a time. It breaks the request into as many external cycles as the configured width needs. For each cycle it drives the low address bits and places the data bytes on the proper external lanes. Lane order is big-endian: a narrow bus always occupies the top lanes, starting at D31 and working downward.

On a read, the bytes returned over several external cycles are collected in holding registers. The assembled value is presented, zero-extended, together with a single-cycle completion pulse. The bus width is read from a static configuration input when a request is accepted. A request that is misaligned, or that carries a reserved size or width code, is refused with an error pulse and starts no external cycle.

Top module: `bus_size_adapter`

## Requirements
- R1: With width code 00 (32-bit bus), a word request (size code 10) makes one external cycle with low address bits 00 and all four lane enables set (ext_be = 1111; ext_be bit 3 is lane D31..D24 and bit 0 is lane D7..D0).
- R2: With width code 01 (16-bit bus), a word request makes two external cycles. The first has low address bits 00 and the second has 10. Both use only lanes D31..D16 (ext_be = 1100), with the upper halfword of the register in the first cycle.
- R3: With width code 10 (8-bit bus), a word request makes four external cycles with low address bits 00, 01, 10 and 11 in that order. Each uses only lane D31..D24 (ext_be = 1000), carrying the register bytes from most significant to least significant.
- R4: A halfword request (size code 01) takes two cycles on an 8-bit bus, most significant byte first, at the request address and then the address plus one, both on lane D31..D24. On a 32-bit bus it takes one cycle on D31..D16 when address bit 1 is clear and on D15..D0 when it is set. On a 16-bit bus it takes one cycle on D31..D16.
- R5: A byte request (size code 00) moves the least significant register byte in one cycle. On a 32-bit bus the lane is chosen by address bits 1:0 (00 gives D31..D24, 11 gives D7..D0). On a 16-bit bus address bit 0 clear gives D31..D24 and set gives D23..D16. On an 8-bit bus the lane is always D31..D24.
- R6: A read returns the gathered bytes on rsp_rdata while rsp_done is high, right-aligned and zero-extended for byte and halfword sizes.
- R7: An external cycle keeps ext_valid, ext_addr, ext_be and ext_wdata unchanged until ext_ready is seen high at a clock edge. Only then does the adapter move on.
- R8: rsp_done is a one-cycle pulse in the cycle after the edge that completes the last external cycle, and it is never high while ext_valid is high.
- R9: The bus width is taken from cfg_width at acceptance, and changing cfg_width during an access has no effect on that access.
- R10: A word request with address bits 1:0 not 00, a halfword request with address bit 0 set, size code 11, or width code 11 raises rsp_done and rsp_err together in the cycle after acceptance, with no external cycle.
- R11: req_ready is high only when the adapter is idle. A request is taken only on a clock edge with req_valid and req_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Store data, right-aligned |
| cfg_width | input | 2 | 00 32-bit, 01 16-bit, 10 8-bit, 11 reserved |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused (with rsp_done) |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |
| ext_valid | output | 1 | External cycle in progress |
| ext_write | output | 1 | Direction of the external cycle |
| ext_addr | output | ADDR_W | Address of the external cycle |
| ext_be | output | 4 | Active lanes, bit 3 = D31..D24 |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| ext_ready | input | 1 | External cycle completes at this edge |

## Verification
Word accesses are run at each of the three widths, in both directions, so that the cycle count, the address stepping and the lane choice for each width are told apart. Halfword and byte accesses are placed at addresses that select different lanes. Unused lanes of read data are filled with filler bytes, so a wrong lane pick or a missing zero-extension shows in the result. Wait states are inserted before ready to separate holding a cycle from advancing it. cfg_width is flipped right after acceptance to show that the width was latched. Misaligned and reserved codes are tried to show that they are refused and that no external cycle starts.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        BW_32   = 2'b00,
        BW_16   = 2'b01,
        BW_8    = 2'b10,
        BW_RSVD = 2'b11
    } bus_width_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BUS  = 2'b01,
        ST_FIN  = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic       write;
        acc_size_e  size;
        bus_width_e width;
        logic [1:0] lo;
    } acc_ctx_t;

    function automatic logic [2:0] size_bytes(input acc_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] width_bytes(input bus_width_e w);
        case (w)
            BW_32:   return 3'd4;
            BW_16:   return 3'd2;
            BW_8:    return 3'd1;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] beat_bytes(input acc_size_e s, input bus_width_e w);
        logic [2:0] sb;
        logic [2:0] wb;
        sb = size_bytes(s);
        wb = width_bytes(w);
        return (sb < wb) ? sb : wb;
    endfunction

    function automatic logic [1:0] last_beat(input acc_size_e s, input bus_width_e w);
        logic [2:0] n;
        n = size_bytes(s) / beat_bytes(s, w);
        return 2'(n - 3'd1);
    endfunction

    function automatic logic access_ok(input acc_size_e s, input bus_width_e w,
                                       input logic [1:0] lo);
        if (w == BW_RSVD || s == SZ_RSVD) return 1'b0;
        if (s == SZ_WORD) return (lo == 2'b00);
        if (s == SZ_HALF) return !lo[0];
        return 1'b1;
    endfunction

endpackage

// File: rtl/bsa_sequencer.sv
module bsa_sequencer
    import bsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        cfg_width,
    input  logic              ext_ready,
    output seq_state_e        state,
    output acc_ctx_t          ctx,
    output logic [ADDR_W-1:2] base,
    output logic [31:0]       wdata,
    output logic [1:0]        beat,
    output logic              err_flag,
    output logic              accept,
    output logic              beat_ack
);

    logic ok;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign beat_ack = (state == ST_BUS) && ext_ready;
    assign ok       = access_ok(acc_size_e'(req_size), bus_width_e'(cfg_width), req_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ctx      <= '0;
            base     <= '0;
            wdata    <= '0;
            beat     <= '0;
            err_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        ctx.write <= req_write;
                        ctx.size  <= acc_size_e'(req_size);
                        ctx.width <= bus_width_e'(cfg_width);
                        ctx.lo    <= req_addr[1:0];
                        base      <= req_addr[ADDR_W-1:2];
                        wdata     <= req_wdata;
                        beat      <= '0;
                        err_flag  <= !ok;
                        state     <= ok ? ST_BUS : ST_FIN;
                    end
                end
                ST_BUS: begin
                    if (ext_ready) begin
                        if (beat == last_beat(ctx.size, ctx.width)) begin
                            state <= ST_FIN;
                        end else begin
                            beat <= beat + 2'd1;
                        end
                    end
                end
                ST_FIN: begin
                    state    <= ST_IDLE;
                    err_flag <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bsa_lane_router.sv
module bsa_lane_router
    import bsa_pkg::*;
(
    input  acc_ctx_t                  ctx,
    input  logic [1:0]                beat,
    input  logic [31:0]               wdata,
    output logic [1:0]                addr_lo,
    output logic [0:LANES-1]          lane_en,
    output logic [0:LANES-1][1:0]     lane_src,
    output logic [0:LANES-1][7:0]     lane_wdata
);

    logic [3:0][7:0] reg_bytes;
    logic [2:0]      sb;
    logic [2:0]      wb;
    logic [2:0]      bb;

    assign reg_bytes = wdata;
    assign sb        = size_bytes(ctx.size);
    assign wb        = width_bytes(ctx.width);
    assign bb        = beat_bytes(ctx.size, ctx.width);
    assign addr_lo   = 2'(int'(ctx.lo) + int'(beat) * int'(bb));

    always_comb begin
        int j;
        int lane_i;
        int ridx;
        lane_en    = '0;
        lane_src   = '0;
        lane_wdata = '0;
        for (int i = 0; i < LANES; i++) begin
            j      = int'(beat) * int'(bb) + i;
            lane_i = (int'(ctx.lo) + j) % int'(wb);
            ridx   = int'(sb) - 1 - j;
            if (i < int'(bb) && j < int'(sb)) begin
                lane_en[lane_i[1:0]]    = 1'b1;
                lane_src[lane_i[1:0]]   = ridx[1:0];
                lane_wdata[lane_i[1:0]] = reg_bytes[ridx[1:0]];
            end
        end
    end

endmodule

// File: rtl/bsa_read_gather.sv
module bsa_read_gather
    import bsa_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clear,
    input  logic                      capture,
    input  logic [0:LANES-1]          lane_en,
    input  logic [0:LANES-1][1:0]     lane_src,
    input  logic [31:0]               ext_rdata,
    output logic [31:0]               assembled
);

    logic [0:LANES-1][7:0] rd_lanes;
    logic [3:0][7:0]       hold;

    assign rd_lanes  = ext_rdata;
    assign assembled = hold;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hold <= '0;
        end else if (capture) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[l]) hold[lane_src[l]] <= rd_lanes[l];
            end
        end
    end

endmodule

// File: rtl/bus_size_adapter.sv
module bus_size_adapter
    import bsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        cfg_width,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              ext_valid,
    output logic              ext_write,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [3:0]        ext_be,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata,
    input  logic              ext_ready
);

    seq_state_e            state;
    acc_ctx_t              ctx;
    logic [ADDR_W-1:2]     base;
    logic [31:0]           cap_wdata;
    logic [1:0]            beat;
    logic                  err_flag;
    logic                  accept;
    logic                  beat_ack;
    logic [1:0]            addr_lo;
    logic [0:LANES-1]      lane_en;
    logic [0:LANES-1][1:0] lane_src;
    logic [0:LANES-1][7:0] lane_wdata;
    logic [31:0]           assembled;
    logic [1:0]            cur_width;

    bsa_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cfg_width (cfg_width),
        .ext_ready (ext_ready),
        .state     (state),
        .ctx       (ctx),
        .base      (base),
        .wdata     (cap_wdata),
        .beat      (beat),
        .err_flag  (err_flag),
        .accept    (accept),
        .beat_ack  (beat_ack)
    );

    bsa_lane_router u_route (
        .ctx        (ctx),
        .beat       (beat),
        .wdata      (cap_wdata),
        .addr_lo    (addr_lo),
        .lane_en    (lane_en),
        .lane_src   (lane_src),
        .lane_wdata (lane_wdata)
    );

    bsa_read_gather u_gather (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .capture   (beat_ack && !ctx.write),
        .lane_en   (lane_en),
        .lane_src  (lane_src),
        .ext_rdata (ext_rdata),
        .assembled (assembled)
    );

    assign cur_width = ctx.width;
    assign req_ready = (state == ST_IDLE);
    assign ext_valid = (state == ST_BUS);
    assign ext_write = ctx.write;
    assign ext_addr  = {base, addr_lo};
    assign ext_be    = lane_en;
    assign ext_wdata = ctx.write ? lane_wdata : '0;
    assign rsp_done  = (state == ST_FIN);
    assign rsp_err   = (state == ST_FIN) && err_flag;
    assign rsp_rdata = (state == ST_FIN && !ctx.write) ? assembled : '0;

endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              ext_valid,
    input logic              ext_ready,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [3:0]        ext_be,
    input logic [31:0]       ext_wdata,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [1:0]        cur_width
);

    p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !ext_ready) |=> (ext_valid && $stable(ext_addr)
                                       && $stable(ext_be) && $stable(ext_wdata)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_done_not_on_bus_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> !ext_valid);

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (rst)
        ext_valid |-> !req_ready);

    p_take_then_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_narrow_top_lane_r3: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && cur_width == 2'b10) |-> (ext_be == 4'b1000));

    p_half_bus_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && cur_width == 2'b01) |-> (ext_be[1:0] == 2'b00 && ext_be != 4'b0000));

endmodule

bind bus_size_adapter bsa_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ext_valid (ext_valid),
    .ext_ready (ext_ready),
    .ext_addr  (ext_addr),
    .ext_be    (ext_be),
    .ext_wdata (ext_wdata),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .cur_width (cur_width)
);

// File: tb/bus_size_adapter_tb.sv
module bus_size_adapter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  cfg_width;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic        ext_valid;
    logic        ext_write;
    logic [31:0] ext_addr;
    logic [3:0]  ext_be;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata;
    logic        ext_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_size_adapter #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_width(cfg_width),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_addr(ext_addr),
        .ext_be(ext_be), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_ready(ext_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic issue(input logic wr, input logic [1:0] sz, input logic [1:0] wcfg,
                         input logic [31:0] addr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = sz;
        req_addr  = addr;
        req_wdata = wd;
        cfg_width = wcfg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 32'h0;
        cfg_width = ~wcfg; // R9: width change after acceptance must be ignored
    endtask

    task automatic do_access(input string tag, input logic wr, input logic [1:0] sz,
                             input logic [1:0] wcfg, input logic [31:0] addr,
                             input logic [31:0] wd, input int nb,
                             input logic [3:0][1:0] elo, input logic [3:0][3:0] ebe,
                             input logic [3:0][31:0] ewd, input logic [3:0][31:0] rdv,
                             input int waits, input logic [31:0] erd);
        issue(wr, sz, wcfg, addr, wd);
        for (int k = 0; k < nb; k++) begin
            for (int w = 0; w <= waits; w++) begin
                // R7: cycle is held with the same address and lanes until ready
                chk({tag, " R7 ext_valid"}, 32'(ext_valid), 32'd1);
                chk({tag, " R11 busy"}, 32'(req_ready), 32'd0);
                chk({tag, " R8 no early done"}, 32'(rsp_done), 32'd0);
                chk({tag, " addr"}, ext_addr, {addr[31:2], elo[k]});
                chk({tag, " lanes"}, 32'(ext_be), 32'(ebe[k]));
                chk({tag, " dir"}, 32'(ext_write), 32'(wr));
                if (wr) chk({tag, " wdata"}, ext_wdata & lane_mask(ext_be), ewd[k]);
                if (w == waits) begin
                    ext_rdata = rdv[k];
                    ext_ready = 1'b1;
                end
                @(posedge clk);
                @(negedge clk);
                ext_ready = 1'b0;
                ext_rdata = 32'hA5A5A5A5;
            end
        end
        chk({tag, " R8 done"}, 32'(rsp_done), 32'd1);
        chk({tag, " R10 no err"}, 32'(rsp_err), 32'd0);
        chk({tag, " R8 bus idle at done"}, 32'(ext_valid), 32'd0);
        if (!wr) chk({tag, " R6 rdata"}, rsp_rdata, erd);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R8 pulse"}, 32'(rsp_done), 32'd0);
        chk({tag, " R11 ready again"}, 32'(req_ready), 32'd1);
    endtask

    task automatic do_error(input string tag, input logic [1:0] sz, input logic [1:0] wcfg,
                            input logic [31:0] addr);
        issue(1'b0, sz, wcfg, addr, 32'h0);
        chk({tag, " R10 done"}, 32'(rsp_done), 32'd1);
        chk({tag, " R10 err"}, 32'(rsp_err), 32'd1);
        chk({tag, " R10 no bus"}, 32'(ext_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R10 no bus after"}, 32'(ext_valid), 32'd0);
        chk({tag, " R11 ready"}, 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset R11 ready", 32'(req_ready), 32'd1);
        chk("reset R7 idle bus", 32'(ext_valid), 32'd0);
        chk("reset R8 done low", 32'(rsp_done), 32'd0);
    endtask

    task automatic t_words();
        // R1
        do_access("R1 word wr 32", 1'b1, 2'b10, 2'b00, 32'h0000_1000, 32'h11223344, 1,
                  {2'd0, 2'd0, 2'd0, 2'b00}, {4'h0, 4'h0, 4'h0, 4'hF},
                  {32'h0, 32'h0, 32'h0, 32'h11223344}, '0, 1, 32'h0);
        do_access("R1 word rd 32", 1'b0, 2'b10, 2'b00, 32'h0000_1004, 32'h0, 1,
                  {2'd0, 2'd0, 2'd0, 2'b00}, {4'h0, 4'h0, 4'h0, 4'hF},
                  '0, {32'h0, 32'h0, 32'h0, 32'hDEADBEEF}, 0, 32'hDEADBEEF);
        // R2
        do_access("R2 word wr 16", 1'b1, 2'b10, 2'b01, 32'h0000_2000, 32'hAABBCCDD, 2,
                  {2'd0, 2'd0, 2'b10, 2'b00}, {4'h0, 4'h0, 4'hC, 4'hC},
                  {32'h0, 32'h0, 32'hCCDD0000, 32'hAABB0000}, '0, 2, 32'h0);
        do_access("R2 word rd 16", 1'b0, 2'b10, 2'b01, 32'h0000_2010, 32'h0, 2,
                  {2'd0, 2'd0, 2'b10, 2'b00}, {4'h0, 4'h0, 4'hC, 4'hC},
                  '0, {32'h0, 32'h0, 32'h5678EEEE, 32'h1234EEEE}, 0, 32'h12345678);
        // R3
        do_access("R3 word rd 8", 1'b0, 2'b10, 2'b10, 32'h0000_3000, 32'h0, 4,
                  {2'b11, 2'b10, 2'b01, 2'b00}, {4'h8, 4'h8, 4'h8, 4'h8},
                  '0, {32'h44999999, 32'h33999999, 32'h22999999, 32'h11999999},
                  1, 32'h11223344);
        do_access("R3 word wr 8", 1'b1, 2'b10, 2'b10, 32'h0000_3010, 32'hCAFEF00D, 4,
                  {2'b11, 2'b10, 2'b01, 2'b00}, {4'h8, 4'h8, 4'h8, 4'h8},
                  {32'h0D000000, 32'hF0000000, 32'hFE000000, 32'hCA000000}, '0, 0, 32'h0);
    endtask

    task automatic t_halves();
        // R4
        do_access("R4 half rd 8", 1'b0, 2'b01, 2'b10, 32'h0000_4002, 32'h0, 2,
                  {2'd0, 2'd0, 2'b11, 2'b10}, {4'h0, 4'h0, 4'h8, 4'h8},
                  '0, {32'h0, 32'h0, 32'hCD555555, 32'hAB555555}, 1, 32'h0000ABCD);
        do_access("R4 half wr 32 hi", 1'b1, 2'b01, 2'b00, 32'h0000_4000, 32'h1234BEEF, 1,
                  {2'd0, 2'd0, 2'd0, 2'b00}, {4'h0, 4'h0, 4'h0, 4'hC},
                  {32'h0, 32'h0, 32'h0, 32'hBEEF0000}, '0, 0, 32'h0);
        do_access("R4 half wr 32 lo", 1'b1, 2'b01, 2'b00, 32'h0000_4002, 32'h1234BEEF, 1,
                  {2'd0, 2'd0, 2'd0, 2'b10}, {4'h0, 4'h0, 4'h0, 4'h3},
                  {32'h0, 32'h0, 32'h0, 32'h0000BEEF}, '0, 0, 32'h0);
        do_access("R4 half rd 32 lo", 1'b0, 2'b01, 2'b00, 32'h0000_4006, 32'h0, 1,
                  {2'd0, 2'd0, 2'd0, 2'b10}, {4'h0, 4'h0, 4'h0, 4'h3},
                  '0, {32'h0, 32'h0, 32'h0, 32'h77776655}, 0, 32'h00006655);
        do_access("R4 half wr 16", 1'b1, 2'b01, 2'b01, 32'h0000_4006, 32'h00007788, 1,
                  {2'd0, 2'd0, 2'd0, 2'b10}, {4'h0, 4'h0, 4'h0, 4'hC},
                  {32'h0, 32'h0, 32'h0, 32'h77880000}, '0, 1, 32'h0);
    endtask

    task automatic t_bytes();
        // R5
        do_access("R5 byte wr 16 odd", 1'b1, 2'b00, 2'b01, 32'h0000_5001, 32'hFFFFFF5A, 1,
                  {2'd0, 2'd0, 2'd0, 2'b01}, {4'h0, 4'h0, 4'h0, 4'h4},
                  {32'h0, 32'h0, 32'h0, 32'h005A0000}, '0, 0, 32'h0);
        do_access("R5 byte wr 16 even", 1'b1, 2'b00, 2'b01, 32'h0000_5000, 32'hFFFFFF5A, 1,
                  {2'd0, 2'd0, 2'd0, 2'b00}, {4'h0, 4'h0, 4'h0, 4'h8},
                  {32'h0, 32'h0, 32'h0, 32'h5A000000}, '0, 0, 32'h0);
        do_access("R5 byte rd 32", 1'b0, 2'b00, 2'b00, 32'h0000_5003, 32'h0, 1,
                  {2'd0, 2'd0, 2'd0, 2'b11}, {4'h0, 4'h0, 4'h0, 4'h1},
                  '0, {32'h0, 32'h0, 32'h0, 32'h777777EE}, 2, 32'h000000EE);
        do_access("R5 byte wr 32 lane1", 1'b1, 2'b00, 2'b00, 32'h0000_5001, 32'h00000042, 1,
                  {2'd0, 2'd0, 2'd0, 2'b01}, {4'h0, 4'h0, 4'h0, 4'h4},
                  {32'h0, 32'h0, 32'h0, 32'h00420000}, '0, 0, 32'h0);
        do_access("R5 byte rd 8", 1'b0, 2'b00, 2'b10, 32'h0000_5002, 32'h0, 1,
                  {2'd0, 2'd0, 2'd0, 2'b10}, {4'h0, 4'h0, 4'h0, 4'h8},
                  '0, {32'h0, 32'h0, 32'h0, 32'h9A123456}, 0, 32'h0000009A);
    endtask

    task automatic t_errors();
        do_error("R10 word misaligned", 2'b10, 2'b00, 32'h0000_6002);
        do_error("R10 half odd", 2'b01, 2'b01, 32'h0000_6003);
        do_error("R10 width rsvd", 2'b10, 2'b11, 32'h0000_6000);
        do_error("R10 size rsvd", 2'b11, 2'b00, 32'h0000_6000);
        // a clean access right after a refusal still works (R9 latch, R1 shape)
        do_access("R9 after err", 1'b0, 2'b10, 2'b00, 32'h0000_6010, 32'h0, 1,
                  {2'd0, 2'd0, 2'd0, 2'b00}, {4'h0, 4'h0, 4'h0, 4'hF},
                  '0, {32'h0, 32'h0, 32'h0, 32'h01020304}, 0, 32'h01020304);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_size  = 2'b00;
        req_addr  = 32'h0;
        req_wdata = 32'h0;
        cfg_width = 2'b00;
        ext_rdata = 32'hA5A5A5A5;
        ext_ready = 1'b0;
        t_reset();
        t_words();
        t_halves();
        t_bytes();
        t_errors();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule